// File: doc/BRIEF.md
# Sparse Index Matcher

This block pairs up the non-zero entries of an activation tile with the non-zero entries of a weight tile that share the same channel index. Two small holders, one per operand, keep a tile of channel indices and their data values. Each holder entry carries a valid flag, so a holder may be partly filled. On `start` the block compares stored input indices against every stored weight index. For each equal pair it emits the input value and the weight value together on a valid/ready stream, one pair per cycle, toward a downstream multiplier.

The comparator budget is chosen per tile through `cmp_lanes`. That many input slots are compared in one compare round, and the tile takes as many rounds as it needs to cover every input slot. A sparse layer can use a wide budget. A dense layer, which yields many pairs per round, can use a narrow one. When the last pair of a tile has been accepted, a single-cycle `tile_done` pulse ends the tile. A tile with no matches ends the same way, without emitting a pair.

Top module: `sparse_idx_match`

## Requirements
- R1: After reset `out_valid` and `tile_done` are low and every holder entry is invalid, so a tile started with no loads emits no pair and ends with `tile_done`.
- R2: With `wr_en` high and the block idle, the entry at `wr_addr` of the input holder (`wr_sel`=0) or of the weight holder (`wr_sel`=1) takes `wr_idx`, `wr_data` and the valid flag `wr_vld`. An entry written with `wr_vld`=0 takes no part in matching.
- R3: Every valid input entry whose index equals the index of a valid weight entry yields exactly one pair: `out_in_idx` carries the index, `out_in_data` the input value and `out_w_data` the weight value. No other pair is emitted.
- R4: `cmp_lanes` is sampled at `start`. A value of 0 acts as 1 and a value above DEPTH acts as DEPTH. The tile takes R = ceil(DEPTH/L) rounds for an effective budget L. With `out_ready` held high and M pairs in the tile, `tile_done` is high in the cycle that follows the 2R+M-th rising edge after the edge that samples `start`.
- R5: Pairs leave in ascending input slot address order across the whole tile.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the pair stays unchanged in the next cycle.
- R7: `tile_done` is a one-cycle pulse raised only after the last pair of the tile has been accepted. `out_valid` stays low after it until the next `start`.
- R8: While a tile is in progress, `start` and holder writes are ignored: the pairs, their count and the timing of the tile are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Holder write strobe |
| wr_sel | input | 1 | 0 selects the input holder, 1 the weight holder |
| wr_addr | input | AW | Holder slot address |
| wr_idx | input | IDX_W | Channel index written to the slot |
| wr_data | input | DAT_W | Data value written to the slot |
| wr_vld | input | 1 | Valid flag written to the slot |
| cmp_lanes | input | LW | Requested comparator budget, input slots per round |
| start | input | 1 | Begin matching the loaded tile |
| out_valid | output | 1 | A matched pair is presented |
| out_ready | input | 1 | Downstream accepts the pair |
| out_in_idx | output | IDX_W | Channel index of the matched pair |
| out_in_data | output | DAT_W | Input value of the pair |
| out_w_data | output | DAT_W | Weight value of the pair |
| tile_done | output | 1 | One-cycle end-of-tile pulse |

## Verification
The bench builds the block with DEPTH of 8 and 8-bit indices and data, which gives a 4-bit `cmp_lanes`. With that width the clamp values 0 and 12 can be driven directly. Budgets of 1, 2, 3, 4 and 8 give 8, 4, 3, 2 and 1 rounds, including a partial last round. The small holder keeps every round count and pair order easy to predict from queues. Randomised-looking ready gaps then exercise back-pressure inside and across rounds.

// File: rtl/sparse_match_pkg.sv
package sparse_match_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CMP   = 2'd1,
      ST_DRAIN = 2'd2
   } match_state_e;

endpackage

// File: rtl/sparse_holder.sv
module sparse_holder #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 8,
   parameter int DAT_W = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [DAT_W-1:0] dat_i,
   input  logic             vld_i,
   output logic [IDX_W-1:0] idx_o [DEPTH],
   output logic [DAT_W-1:0] dat_o [DEPTH],
   output logic [DEPTH-1:0] vld_o
);

   generate
      if (DEPTH < 2 || IDX_W < 1 || DAT_W < 1) begin : g_bad_cfg
         $error("sparse_holder: DEPTH must be >= 2 and widths >= 1");
      end
   endgenerate

   logic in_range;
   assign in_range = int'(addr) < DEPTH;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= '0;
      end else if (we && in_range) begin
         idx_o[addr] <= idx_i;
         dat_o[addr] <= dat_i;
         vld_o[addr] <= vld_i;
      end
   end

endmodule

// File: rtl/sparse_cmp_lane.sv
module sparse_cmp_lane #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 8,
   parameter int DAT_W = 8
) (
   input  logic             en,
   input  logic [IDX_W-1:0] key,
   input  logic [IDX_W-1:0] w_idx [DEPTH],
   input  logic [DAT_W-1:0] w_dat [DEPTH],
   input  logic [DEPTH-1:0] w_vld,
   output logic             hit,
   output logic [DAT_W-1:0] w_dat_o
);

   logic [DEPTH-1:0] eq;

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_cmp
         assign eq[w] = w_vld[w] && (w_idx[w] == key);
      end
   endgenerate

   always_comb begin
      w_dat_o = '0;
      for (int w = 0; w < DEPTH; w++) begin
         if (eq[w]) w_dat_o = w_dat_o | w_dat[w];
      end
      hit = en && (|eq);
   end

endmodule

// File: rtl/sparse_pick_low.sv
module sparse_pick_low #(
   parameter int LANES = 16,
   localparam int SLW  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] req,
   output logic             any,
   output logic [SLW-1:0]   sel
);

   always_comb begin
      sel = '0;
      for (int j = LANES - 1; j >= 0; j--) begin
         if (req[j]) sel = SLW'(j);
      end
      any = |req;
   end

endmodule

// File: rtl/sparse_idx_match.sv
module sparse_idx_match
   import sparse_match_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 8,
   parameter int DAT_W = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [AW-1:0]    wr_addr,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DAT_W-1:0] wr_data,
   input  logic             wr_vld,
   input  logic [LW-1:0]    cmp_lanes,
   input  logic             start,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [IDX_W-1:0] out_in_idx,
   output logic [DAT_W-1:0] out_in_data,
   output logic [DAT_W-1:0] out_w_data,
   output logic             tile_done
);

   localparam int LANES = DEPTH;
   localparam int SW    = AW + 1;
   localparam int SLW   = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (DEPTH < 2 || IDX_W < 1 || DAT_W < 1) begin : g_bad_cfg
         $error("sparse_idx_match: DEPTH must be >= 2 and widths >= 1");
      end
   endgenerate

   match_state_e     st_q;
   logic [LW-1:0]    lanes_q;
   logic [LW-1:0]    lanes_eff;
   logic [SW-1:0]    base_q;

   // holders: writes only land while idle (R2, R8)
   logic [IDX_W-1:0] a_idx [DEPTH];
   logic [DAT_W-1:0] a_dat [DEPTH];
   logic [DEPTH-1:0] a_vld;
   logic [IDX_W-1:0] b_idx [DEPTH];
   logic [DAT_W-1:0] b_dat [DEPTH];
   logic [DEPTH-1:0] b_vld;
   logic             idle;

   assign idle = (st_q == ST_IDLE);

   sparse_holder #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DAT_W(DAT_W)) u_in_hold (
      .clk(clk), .rst_n(rst_n), .we(wr_en && idle && !wr_sel), .addr(wr_addr),
      .idx_i(wr_idx), .dat_i(wr_data), .vld_i(wr_vld),
      .idx_o(a_idx), .dat_o(a_dat), .vld_o(a_vld)
   );

   sparse_holder #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DAT_W(DAT_W)) u_w_hold (
      .clk(clk), .rst_n(rst_n), .we(wr_en && idle && wr_sel), .addr(wr_addr),
      .idx_i(wr_idx), .dat_i(wr_data), .vld_i(wr_vld),
      .idx_o(b_idx), .dat_o(b_dat), .vld_o(b_vld)
   );

   // budget clamp (R4)
   always_comb begin
      if (cmp_lanes == '0)              lanes_eff = LW'(1);
      else if (int'(cmp_lanes) > DEPTH) lanes_eff = LW'(DEPTH);
      else                              lanes_eff = cmp_lanes;
   end

   // lane array: lane j compares input slot base+j against every weight
   logic [LANES-1:0] hit_c;
   logic [DAT_W-1:0] wd_c   [LANES];
   logic [IDX_W-1:0] key_c  [LANES];
   logic [DAT_W-1:0] ad_c   [LANES];

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         logic [SW-1:0] slot;
         logic [AW-1:0] slot_t;
         logic          en;
         assign slot   = base_q + SW'(j);
         assign slot_t = slot[AW-1:0];
         assign en     = (j < int'(lanes_q)) && (int'(slot) < DEPTH) && a_vld[slot_t];
         assign key_c[j] = a_idx[slot_t];
         assign ad_c[j]  = a_dat[slot_t];

         sparse_cmp_lane #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DAT_W(DAT_W)) u_cmp (
            .en(en), .key(key_c[j]), .w_idx(b_idx), .w_dat(b_dat), .w_vld(b_vld),
            .hit(hit_c[j]), .w_dat_o(wd_c[j])
         );
      end
   endgenerate

   // round result set
   logic [LANES-1:0] hit_q;
   logic [IDX_W-1:0] key_q [LANES];
   logic [DAT_W-1:0] ad_q  [LANES];
   logic [DAT_W-1:0] wd_q  [LANES];
   logic             any;
   logic [SLW-1:0]   out_sel;
   logic             fire;
   logic             last_round;

   sparse_pick_low #(.LANES(LANES)) u_pick (
      .req(hit_q), .any(any), .sel(out_sel)
   );

   assign out_valid   = (st_q == ST_DRAIN) && any;
   assign out_in_idx  = key_q[out_sel];
   assign out_in_data = ad_q[out_sel];
   assign out_w_data  = wd_q[out_sel];
   assign fire        = out_valid && out_ready;
   assign last_round  = (int'(base_q) + int'(lanes_q)) >= DEPTH;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         lanes_q   <= LW'(1);
         base_q    <= '0;
         hit_q     <= '0;
         tile_done <= 1'b0;
      end else begin
         tile_done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  lanes_q <= lanes_eff;
                  base_q  <= '0;
                  st_q    <= ST_CMP;
               end
            end
            ST_CMP: begin
               hit_q <= hit_c;
               for (int j = 0; j < LANES; j++) begin
                  key_q[j] <= key_c[j];
                  ad_q[j]  <= ad_c[j];
                  wd_q[j]  <= wd_c[j];
               end
               st_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               if (any) begin
                  if (fire) hit_q[out_sel] <= 1'b0;
               end else if (last_round) begin
                  tile_done <= 1'b1;
                  st_q      <= ST_IDLE;
               end else begin
                  base_q <= base_q + SW'(lanes_q);
                  st_q   <= ST_CMP;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R6: a refused pair is held unchanged
   p_hold_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_in_idx)
                                     && $stable(out_in_data) && $stable(out_w_data)));

   // R7: end-of-tile is a single-cycle pulse with nothing pending
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tile_done |=> !tile_done);
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tile_done |-> !out_valid);

   // R4: a round never holds more hits than the budget allows
   p_lane_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN) |-> ($countones(hit_q) <= int'(lanes_q)));

   // R5: the next pair of a round comes from a higher lane
   p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && $countones(hit_q) > 1) |=> (out_valid && out_sel > $past(out_sel)));

   // R8: a start while busy does not reload the budget
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start) |=> $stable(lanes_q));

endmodule

// File: tb/sparse_idx_match_tb.sv
`timescale 1ns/1ps
module sparse_idx_match_tb_top;

   localparam int DEPTH = 8;
   localparam int AW    = 3;
   localparam int LW    = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en, wr_sel, wr_vld;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_idx, wr_data;
   logic [LW-1:0] cmp_lanes;
   logic          start;
   logic          out_valid, out_ready;
   logic [7:0]    out_in_idx, out_in_data, out_w_data;
   logic          tile_done;

   int checks = 0;
   int errors = 0;
   int total_cyc = 0;

   // shadow of what the bench loaded
   int s_a_idx [DEPTH], s_a_dat [DEPTH], s_a_v [DEPTH];
   int s_b_idx [DEPTH], s_b_dat [DEPTH], s_b_v [DEPTH];

   always #4 clk = ~clk;

   sparse_idx_match #(.DEPTH(DEPTH), .IDX_W(8), .DAT_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_idx(wr_idx), .wr_data(wr_data), .wr_vld(wr_vld), .cmp_lanes(cmp_lanes),
      .start(start), .out_valid(out_valid), .out_ready(out_ready),
      .out_in_idx(out_in_idx), .out_in_data(out_in_data), .out_w_data(out_w_data),
      .tile_done(tile_done)
   );

   always @(posedge clk) begin
      total_cyc++;
      if (total_cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<=%0d", total_cyc, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input int addr, input int idx, input int dat, input bit v);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(addr);
      wr_idx = 8'(idx); wr_data = 8'(dat); wr_vld = v;
      if (!sel) begin s_a_idx[addr] = idx; s_a_dat[addr] = dat; s_a_v[addr] = v; end
      else      begin s_b_idx[addr] = idx; s_b_dat[addr] = dat; s_b_v[addr] = v; end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // rmode 0: ready always high; rmode 1: ready low one cycle in three
   task automatic run_tile(input int lanes, input int rmode, input bit poke, input bit chk_lat);
      int exp_q[$];
      int got_q[$];
      int eff, rounds, cyc, prev_pair;
      bit done, prev_stall;
      eff = (lanes == 0) ? 1 : ((lanes > DEPTH) ? DEPTH : lanes);
      rounds = (DEPTH + eff - 1) / eff;
      for (int i = 0; i < DEPTH; i++)
         for (int w = 0; w < DEPTH; w++)
            if (s_a_v[i] != 0 && s_b_v[w] != 0 && s_a_idx[i] == s_b_idx[w])
               exp_q.push_back((s_a_idx[i] << 16) | (s_a_dat[i] << 8) | s_b_dat[w]);
      @(negedge clk);
      cmp_lanes = LW'(lanes);
      start = 1'b1;
      out_ready = 1'b1;
      cyc = 0; done = 1'b0; prev_stall = 1'b0; prev_pair = 0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         start = poke && (cyc == 3);
         if (poke && cyc == 3) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = AW'(7);
            wr_idx = 8'd99; wr_data = 8'h5A; wr_vld = 1'b1;
         end else begin
            wr_en = 1'b0;
         end
         if (prev_stall) begin
            chk(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
            chk({out_in_idx, out_in_data, out_w_data} == 24'(prev_pair), "R6 pair held",
                int'({out_in_idx, out_in_data, out_w_data}), prev_pair);
         end
         out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
         if (out_valid && out_ready)
            got_q.push_back(int'({out_in_idx, out_in_data, out_w_data}));
         prev_stall = out_valid && !out_ready;
         prev_pair  = int'({out_in_idx, out_in_data, out_w_data});
         if (tile_done) done = 1'b1;
      end
      wr_en = 1'b0;
      start = 1'b0;
      out_ready = 1'b1;
      chk(done, "R7 tile_done seen", int'(done), 1);
      if (chk_lat)
         chk(cyc == 2 * rounds + exp_q.size() + 1, "R4 tile latency", cyc,
             2 * rounds + exp_q.size() + 1);
      chk(got_q.size() == exp_q.size(), "R3 pair count", got_q.size(), exp_q.size());
      for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
         chk(got_q[k] == exp_q[k], "R5 pair order/content", got_q[k], exp_q[k]);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!tile_done && !out_valid, "R7 quiet after done (R8 no second tile)",
             int'({tile_done, out_valid}), 0);
      end
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_idx = '0;
      wr_data = '0; wr_vld = 1'b0; cmp_lanes = '0; start = 1'b0; out_ready = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         s_a_idx[i] = 0; s_a_dat[i] = 0; s_a_v[i] = 0;
         s_b_idx[i] = 0; s_b_dat[i] = 0; s_b_v[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      chk(tile_done == 1'b0, "R1 reset tile_done", int'(tile_done), 0);
      rst_n = 1'b1;

      // R1: empty holders give a tile with no pairs
      run_tile(8, 0, 1'b0, 1'b1);

      // load a tile: inputs 1,4,7,...,22; weights match 5 of them
      for (int i = 0; i < DEPTH; i++) wr(1'b0, i, i * 3 + 1, 8'h10 + i, 1'b1);
      wr(1'b1, 0, 22, 8'hA0, 1'b1);
      wr(1'b1, 1, 4,  8'hA1, 1'b1);
      wr(1'b1, 2, 5,  8'hA2, 1'b1);
      wr(1'b1, 3, 13, 8'hA3, 1'b1);
      wr(1'b1, 4, 2,  8'hA4, 1'b1);
      wr(1'b1, 5, 10, 8'hA5, 1'b1);
      wr(1'b1, 6, 30, 8'hA6, 1'b1);
      wr(1'b1, 7, 1,  8'hA7, 1'b1);

      run_tile(3, 0, 1'b0, 1'b1);   // R3 R4 R5: partial last round
      run_tile(0, 0, 1'b0, 1'b1);   // R4: zero budget acts as one lane
      run_tile(12, 0, 1'b0, 1'b1);  // R4: oversize budget clamps to DEPTH
      run_tile(2, 1, 1'b0, 1'b0);   // R6: back-pressure

      // R2: invalidate one weight, retarget one input
      wr(1'b1, 3, 13, 8'hA3, 1'b0);
      wr(1'b0, 5, 30, 8'h77, 1'b1);
      run_tile(4, 0, 1'b0, 1'b1);

      // R8: start and a write issued mid-tile are ignored
      run_tile(2, 0, 1'b1, 1'b1);
      run_tile(1, 1, 1'b0, 1'b0);

      // R7: disjoint indices give an empty tile
      for (int w = 0; w < DEPTH; w++) wr(1'b1, w, 200 + w, w, 1'b1);
      run_tile(5, 0, 1'b0, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule